// File: doc/BRIEF.md
# MFM Byte Writer with Reserve Buffer

This block turns a stream of host bytes into the flux pattern that drives a floppy write head, using modified frequency modulation (MFM). Each bit cell is split into a clock half and a data half. A clock pulse is written only between two zero data bits, and an 8-bit clock mask can suppress it to form the missing-clock sync marks that a reader uses to frame sectors. The data byte $A1 sent with mask $FB is the standard sync mark. Ordinary bytes use mask $FF.

The host delivers data bytes over a valid/ready stream and updates a separate clock-mask register with a plain write strobe. Besides the byte being shifted out, the block holds one spare byte, so the host has a whole byte time to answer a request. A data byte is taken into the spare slot as soon as it is offered. The clock mask is sampled only when that spare byte moves into the shift stage. This matches a host that writes the data register first and the clock register a few instructions later. The bit-cell rate comes from a density selector: double density uses a base half-cell length, and the two faster modes run at twice and four times that rate. If the shift stage needs a byte and none is waiting, the block fills with gap bytes and raises a sticky underrun flag.

Top module: `mfm_byte_writer`

## Requirements
- R1: After reset, `data_ready` is 1, `flux_out`, `half_tick` and `underrun` are 0, and the clock-mask register holds $FF.
- R2: `data_ready` is 1 exactly when the spare slot is empty. A byte is accepted on a rising edge where `data_valid` and `data_ready` are both 1. `data_ready` is 0 from the next cycle on. A `data_valid` while `data_ready` is 0 is ignored and does not change the byte held.
- R3: An accepted byte is held in the spare slot at once, even while the run is stopped. `data_ready` returns to 1 in the same cycle that `half_tick` marks the first half-cell of that byte, and never at any other time.
- R4: The clock mask applied to a byte is the clock-mask register value on the cycle the byte moves from the spare slot to the shift stage. Mask writes made after the data write but before the move apply to that byte. Mask writes made after the move affect only later bytes.
- R5: Bytes are sent MSB first. Each bit produces a clock half-cell followed by a data half-cell. The data half equals the bit. The clock half is 1 only when the previous data bit and the current data bit are both 0 and the matching mask bit is 1. The previous data bit counts as 0 at the start of a run. No two consecutive half-cells are both 1.
- R6: Data $A1 with mask $FB produces the half-cell sequence 0100 0100 1000 1001 ($4489), whatever the previous byte was.
- R7: A half-cell lasts HALF_CELL_DD clock cycles when `density` is 0, HALF_CELL_DD/2 when it is 1, and HALF_CELL_DD/4 when it is 2 or 3.
- R8: While `run` is 0 the block emits no half-cells, and `flux_out` and `half_tick` are 0. When `run` is 1 and the block is idle, the first half-cell starts one cycle later, shown by `half_tick`.
- R9: When the shift stage needs a byte and the spare slot is empty, the block sends data $4E with mask $FF and sets `underrun`. `underrun` stays 1 until `run` is 0, which clears it on the next cycle.
- R10: `half_tick` is a one-cycle pulse at the start of each half-cell. `flux_out` changes only in cycles where `half_tick` is 1, or when `run` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Write enable; 0 aborts and idles the serializer |
| density | input | 2 | Rate select: 0 base, 1 twice, 2 or 3 four times |
| data_valid | input | 1 | Host offers a data byte |
| data_in | input | 8 | Data byte |
| data_ready | output | 1 | Spare slot empty (request for next byte) |
| clk_mask_wr | input | 1 | Strobe that loads the clock-mask register |
| clk_mask_in | input | 8 | Clock-mask value |
| flux_out | output | 1 | Write-data level for the current half-cell |
| half_tick | output | 1 | Pulse marking the start of a half-cell |
| underrun | output | 1 | Sticky: a gap byte was inserted for lack of data |

## Verification
A spare-slot flag stuck full or empty shows on `data_ready` on the cycle after a write, or at the next byte boundary. A mask captured at the wrong point (at the data write rather than at the transfer) changes a clock half-cell inside the affected byte. That error appears on `flux_out` no later than one byte time after the transfer. An off-by-one in the bit counter or the previous-bit memory breaks the adjacent-ones rule or the $4489 sync pattern within the next sixteen half-cells. A wrong divider limit shows in the spacing of the first two `half_tick` pulses.

// File: rtl/mfm_wr_pkg.sv
package mfm_wr_pkg;

  localparam logic [7:0] GAP_DATA = 8'h4E;
  localparam logic [7:0] GAP_MASK = 8'hFF;

  typedef struct packed {
    logic [7:0] data;
    logic [7:0] mask;
  } mfm_byte_t;

  // Clock half-cell: pulse only between two zero data bits, when allowed by the mask.
  function automatic logic clock_half(input logic prev_bit, input logic cur_bit,
                                      input logic mask_bit);
    return mask_bit & ~prev_bit & ~cur_bit;
  endfunction

endpackage

// File: rtl/mfm_rate_gen.sv
module mfm_rate_gen #(
  parameter int HALF_CELL_DD = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] density,
  output logic       tick
);
  localparam int CNT_W  = (HALF_CELL_DD > 2) ? $clog2(HALF_CELL_DD) : 1;
  localparam int LIM_DD = HALF_CELL_DD - 1;
  localparam int LIM_HD = HALF_CELL_DD / 2 - 1;
  localparam int LIM_ED = HALF_CELL_DD / 4 - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  always_comb begin
    case (density)
      2'd0:    lim = CNT_W'(LIM_DD);
      2'd1:    lim = CNT_W'(LIM_HD);
      default: lim = CNT_W'(LIM_ED);
    endcase
  end

  assign tick = en && (cnt_q >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n || !en || tick) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mfm_reserve.sv
module mfm_reserve (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       take,
  output logic       in_ready,
  output logic       full,
  output logic [7:0] res_data
);
  logic       full_q;
  logic [7:0] data_q;
  logic       accept;

  assign accept   = in_valid && !full_q;
  assign in_ready = !full_q;
  assign full     = full_q;
  assign res_data = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (accept) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mfm_shifter.sv
module mfm_shifter
  import mfm_wr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick,
  input  logic       res_full,
  input  logic [7:0] res_data,
  input  logic [7:0] mask_reg,
  output logic       take,
  output logic       active,
  output logic       flux,
  output logic       half_tick,
  output logic       underrun
);
  logic       active_q, phase_q, prev_q, flux_q, ht_q, und_q;
  logic [2:0] cnt_q;
  logic [7:0] sh_data;
  logic [6:0] sh_mask;
  logic       end_of_byte, load;
  mfm_byte_t  src;

  assign end_of_byte = active_q && tick && phase_q && (cnt_q == 3'd7);
  assign load        = run && (!active_q || end_of_byte);
  assign take        = load && res_full;
  assign src         = res_full ? '{data: res_data, mask: mask_reg}
                                : '{data: GAP_DATA, mask: GAP_MASK};

  assign active    = active_q;
  assign flux      = flux_q;
  assign half_tick = ht_q;
  assign underrun  = und_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      prev_q   <= 1'b0;
      flux_q   <= 1'b0;
      ht_q     <= 1'b0;
      und_q    <= 1'b0;
      cnt_q    <= '0;
      sh_data  <= '0;
      sh_mask  <= '0;
    end else begin
      ht_q <= 1'b0;
      if (load) begin
        active_q <= 1'b1;
        sh_data  <= src.data;
        sh_mask  <= src.mask[6:0];
        cnt_q    <= '0;
        phase_q  <= 1'b0;
        flux_q   <= clock_half(prev_q, src.data[7], src.mask[7]);
        ht_q     <= 1'b1;
        if (!res_full) und_q <= 1'b1;
      end else if (tick) begin
        ht_q <= 1'b1;
        if (!phase_q) begin
          phase_q <= 1'b1;
          flux_q  <= sh_data[7];
          prev_q  <= sh_data[7];
        end else begin
          phase_q <= 1'b0;
          cnt_q   <= cnt_q + 3'd1;
          sh_data <= {sh_data[6:0], 1'b0};
          sh_mask <= {sh_mask[5:0], 1'b0};
          flux_q  <= clock_half(prev_q, sh_data[6], sh_mask[6]);
        end
      end
    end
  end
endmodule

// File: rtl/mfm_byte_writer.sv
module mfm_byte_writer #(
  parameter int HALF_CELL_DD = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] density,
  input  logic       data_valid,
  input  logic [7:0] data_in,
  output logic       data_ready,
  input  logic       clk_mask_wr,
  input  logic [7:0] clk_mask_in,
  output logic       flux_out,
  output logic       half_tick,
  output logic       underrun
);
  logic [7:0] mask_reg;
  logic       res_full, take, active, tick;
  logic [7:0] res_data;

  always_ff @(posedge clk) begin
    if (!rst_n)           mask_reg <= 8'hFF;
    else if (clk_mask_wr) mask_reg <= clk_mask_in;
  end

  mfm_reserve u_reserve (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (data_valid),
    .in_data  (data_in),
    .take     (take),
    .in_ready (data_ready),
    .full     (res_full),
    .res_data (res_data)
  );

  mfm_rate_gen #(.HALF_CELL_DD(HALF_CELL_DD)) u_rate (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (active),
    .density (density),
    .tick    (tick)
  );

  mfm_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tick      (tick),
    .res_full  (res_full),
    .res_data  (res_data),
    .mask_reg  (mask_reg),
    .take      (take),
    .active    (active),
    .flux      (flux_out),
    .half_tick (half_tick),
    .underrun  (underrun)
  );
endmodule

// File: rtl/mfm_byte_writer_chk.sv
module mfm_byte_writer_chk #(
  parameter int HALF_CELL_DD = 200
) (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic [1:0] density,
  input logic       data_valid,
  input logic       data_ready,
  input logic       flux_out,
  input logic       half_tick,
  input logic       underrun
);
  logic        last_flux, seen;
  logic [15:0] gap_cnt;
  int          exp_len;

  assign exp_len = HALF_CELL_DD >> ((density == 2'd3) ? 2 : int'(density));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      last_flux <= 1'b0;
      seen      <= 1'b0;
      gap_cnt   <= '0;
    end else if (half_tick) begin
      last_flux <= flux_out;
      seen      <= 1'b1;
      gap_cnt   <= 16'd1;
    end else if (gap_cnt != 16'hFFFF) begin
      gap_cnt   <= gap_cnt + 16'd1;
    end
  end

  assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && data_ready) |=> !data_ready);

  assert_ready_with_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> half_tick);

  assert_no_adjacent_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && flux_out && seen) |-> !last_flux);

  assert_cell_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && seen && run) |-> (int'(gap_cnt) == exp_len));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!half_tick && !flux_out));

  assert_underrun_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !underrun);

  assert_flux_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !half_tick) |-> $stable(flux_out));
endmodule

bind mfm_byte_writer mfm_byte_writer_chk #(.HALF_CELL_DD(HALF_CELL_DD)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .density    (density),
  .data_valid (data_valid),
  .data_ready (data_ready),
  .flux_out   (flux_out),
  .half_tick  (half_tick),
  .underrun   (underrun)
);

// File: tb/mfm_byte_writer_bench.sv
`timescale 1ns/1ps
module mfm_byte_writer_bench;
  localparam int HC   = 8;
  localparam int NVEC = 8;
  localparam int NCAP = 1024;
  // {data, clock mask}; expected flux is derived from R5 by enc()
  localparam logic [15:0] VEC [0:NVEC-1] = '{
    16'h4EFF, 16'hA1FB, 16'hA1FB, 16'hA1FB,
    16'hFEFF, 16'h00FF, 16'hFFFF, 16'h55FF};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [1:0] density = 2'd0;
  logic data_valid = 1'b0;
  logic [7:0] data_in = '0;
  logic clk_mask_wr = 1'b0;
  logic [7:0] clk_mask_in = '0;
  logic data_ready, flux_out, half_tick, underrun;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;
  int cyc = 0;
  int ncap = 0;
  logic cap [0:NCAP-1];
  int   tcyc [0:NCAP-1];

  always #2.5 clk = ~clk;

  mfm_byte_writer #(.HALF_CELL_DD(HC)) u_mfm_byte_writer (
    .clk(clk), .rst_n(rst_n), .run(run), .density(density),
    .data_valid(data_valid), .data_in(data_in), .data_ready(data_ready),
    .clk_mask_wr(clk_mask_wr), .clk_mask_in(clk_mask_in),
    .flux_out(flux_out), .half_tick(half_tick), .underrun(underrun));

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (half_tick && ncap < NCAP) begin
      cap[ncap]  = flux_out;
      tcyc[ncap] = cyc;
      ncap = ncap + 1;
    end
  end

  function automatic logic [15:0] enc(input logic prev, input logic [7:0] d,
                                      input logic [7:0] m);
    logic [15:0] r;
    logic p;
    p = prev;
    for (int i = 7; i >= 0; i--) begin
      r[2*i+1] = m[i] && !p && !d[i];
      r[2*i]   = d[i];
      p = d[i];
    end
    return r;
  endfunction

  function automatic logic [15:0] cap_word(input int start);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[15-i] = cap[start+i];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push_data(input logic [7:0] d);
    while (!data_ready) @(negedge clk);
    data_valid = 1'b1; data_in = d;
    @(negedge clk);
    data_valid = 1'b0;
    check(data_ready == 1'b0, "R2 ready low after accept", data_ready, 0);
    data_valid = 1'b1; data_in = 8'hC3;   // offered while not ready: must be ignored
    @(negedge clk);
    data_valid = 1'b0;
  endtask

  task automatic push_mask(input logic [7:0] m);
    clk_mask_wr = 1'b1; clk_mask_in = m;
    @(negedge clk);
    clk_mask_wr = 1'b0;
  endtask

  task automatic wait_caps(input int n);
    while (ncap < n) @(negedge clk);
  endtask

  task automatic stop_run();
    run = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    logic p;
    logic [15:0] e;
    bit ok;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(data_ready == 1'b1, "R1 data_ready", data_ready, 1);
    check({flux_out, half_tick, underrun} == 3'b000, "R1 outputs idle",
          {flux_out, half_tick, underrun}, 0);

    // Preload while stopped (R3), then start (R8)
    push_data(VEC[0][15:8]);
    push_mask(VEC[0][7:0]);
    check(data_ready == 1'b0, "R3 byte held while stopped", data_ready, 0);
    ncap = 0;
    run = 1'b1;
    @(negedge clk);
    check(half_tick == 1'b1, "R8 first half-cell one cycle after run", half_tick, 1);
    check(data_ready == 1'b1, "R3 ready with first half-cell", data_ready, 1);

    // Table walk: data first, mask a little later (R4 ordering)
    for (int i = 1; i < NVEC; i++) begin
      push_data(VEC[i][15:8]);
      @(negedge clk);
      push_mask(VEC[i][7:0]);
      check(underrun == 1'b0, "R9 no underrun while fed", underrun, 0);
    end

    wait_caps(160);
    check(underrun == 1'b1, "R9 underrun after starvation", underrun, 1);
    check(data_ready == 1'b1, "R2 ready while slot empty", data_ready, 1);

    p = 1'b0;
    for (int b = 0; b < 10; b++) begin
      logic [7:0] d, m;
      d = (b < NVEC) ? VEC[b][15:8] : 8'h4E;
      m = (b < NVEC) ? VEC[b][7:0]  : 8'hFF;
      e = enc(p, d, m);
      if (b >= 1 && b <= 3)
        check(cap_word(16*b) == e, "R4 R6 sync byte mask at transfer", cap_word(16*b), e);
      else if (b >= NVEC)
        check(cap_word(16*b) == e, "R9 gap byte 4E/FF", cap_word(16*b), e);
      else
        check(cap_word(16*b) == e, "R5 R2 encoded byte", cap_word(16*b), e);
      p = d[0];
    end
    check(cap_word(16*3) == 16'h4489, "R6 sync pattern", cap_word(16*3), 16'h4489);

    ok = 1'b1;
    for (int i = 1; i < 160; i++) if (tcyc[i] - tcyc[i-1] != HC) ok = 1'b0;
    check(ok, "R7 R10 base half-cell length", tcyc[1] - tcyc[0], HC);

    stop_run();
    check({flux_out, half_tick, underrun} == 3'b000, "R8 R9 stopped outputs",
          {flux_out, half_tick, underrun}, 0);

    // Start with an empty slot: gap byte first (R9); faster densities (R7)
    for (int dsel = 1; dsel < 4; dsel++) begin
      density = 2'(dsel);
      ncap = 0;
      run = 1'b1;
      wait_caps(17);
      check(tcyc[2] - tcyc[1] == (HC >> ((dsel == 3) ? 2 : dsel)), "R7 density length",
            tcyc[2] - tcyc[1], HC >> ((dsel == 3) ? 2 : dsel));
      check(cap_word(0) == enc(1'b0, 8'h4E, 8'hFF), "R9 gap at start", cap_word(0),
            enc(1'b0, 8'h4E, 8'hFF));
      check(underrun == 1'b1, "R9 underrun at empty start", underrun, 1);
      stop_run();
    end

    // R4: mask rewritten after the data write, before transfer, applies to the byte
    density = 2'd0;
    push_data(8'h00);
    push_mask(8'hEF);
    push_mask(8'hFF);
    ncap = 0;
    run = 1'b1;
    wait_caps(16);
    check(cap_word(0) == enc(1'b0, 8'h00, 8'hFF), "R4 late mask write applies",
          cap_word(0), enc(1'b0, 8'h00, 8'hFF));
    stop_run();

    // R4: mask written after transfer leaves the in-flight byte alone
    push_data(8'h00);
    push_mask(8'hEF);
    ncap = 0;
    run = 1'b1;
    @(negedge clk);
    push_mask(8'hFF);
    wait_caps(16);
    check(cap_word(0) == enc(1'b0, 8'h00, 8'hEF), "R4 mask after transfer ignored",
          cap_word(0), enc(1'b0, 8'h00, 8'hEF));
    stop_run();

    finish_up();
  end
endmodule